// File: doc/BRIEF.md
# Threshold Interrupt Pulse Generator

The block raises three interrupt pulses for a time-to-digital converter core, each high for one clock cycle. The count interrupt fires once the number of timestamps stored since the previous interrupt, or since acquisition start, is greater than a host-set count threshold. The time interrupt fires when at least one timestamp is waiting and the number of whole milliseconds elapsed since the previous interrupt, or since acquisition start, is greater than a host-set threshold. The error interrupt marks each rising edge of the converter's error flag, which reports that the hit FIFOs are full.

A prescaler divides the clock into a millisecond tick. With the default 125 MHz clock, one tick comes every 125000 cycles. The tick advances the elapsed-time counter. When either the count or the time interrupt fires, the timestamp counter, the elapsed-time counter and the prescaler all restart. Acquisition is armed and disarmed by single-cycle start and stop pulses from the control logic.

Top module: `irq_pulse_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all three interrupt outputs are low.
- R2: The count and time interrupt outputs are never high for two consecutive cycles.
- R3: While acquisition is armed, the cycle after the timestamp counter first becomes greater than the count threshold, `irq_cnt_o` is high. The counter advances once per cycle in which `tstamp_i` is high.
- R4: The elapsed-time counter advances once every TICK_CYCLES armed cycles. `irq_time_o` is high the cycle after that counter becomes greater than the millisecond threshold, provided the timestamp counter is nonzero.
- R5: With no timestamp stored in the current interval, the time interrupt never fires, however much time passes.
- R6: When the count or time interrupt fires, the timestamp counter, the elapsed-time counter and the prescaler all return to zero.
- R7: A timestamp that arrives in the same cycle as a firing interrupt is counted toward the next interval. The counter restarts at one instead of zero.
- R8: A start pulse clears all counters, and a timestamp in that cycle is dropped. While disarmed, and in any cycle with a start or stop pulse, neither the count nor the time interrupt fires. When start and stop arrive together, acquisition ends up disarmed.
- R9: A count threshold of zero disables the count interrupt. A millisecond threshold of zero disables the time interrupt.
- R10: The cycle after each 0-to-1 transition of `err_flag_i`, `irq_err_o` is high for exactly one cycle. This holds whether or not acquisition is armed, and a flag held high gives only one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_cnt_i | input | CNT_W | Timestamp count threshold, 0 disables |
| thr_ms_i | input | CNT_W | Elapsed-time threshold in milliseconds, 0 disables |
| tstamp_i | input | 1 | One-cycle pulse per stored timestamp |
| err_flag_i | input | 1 | Converter error flag level (hit FIFOs full) |
| acq_start_i | input | 1 | One-cycle pulse that arms acquisition |
| acq_stop_i | input | 1 | One-cycle pulse that disarms acquisition |
| irq_cnt_o | output | 1 | Count threshold interrupt pulse |
| irq_time_o | output | 1 | Elapsed-time interrupt pulse |
| irq_err_o | output | 1 | Error flag rising-edge interrupt pulse |

## Verification
The bench builds the block with TICK_CYCLES set to 8 and CNT_W set to 16. A multi-millisecond timeout therefore lasts a few dozen cycles, so time interrupts, the restart of the prescaler after a firing, and races between a tick and a timestamp all occur many times in a short run. Small random thresholds, including zero, make both interrupts fire often. Start and stop pulses are scattered through the run, and some land on the same cycle as a firing.

// File: rtl/irq_gen_pkg.sv
package irq_gen_pkg;
  // control word shared by the saturating counters
  typedef struct packed {
    logic clr;
    logic load_one;
    logic inc;
  } cnt_ctrl_t;
endpackage

// File: rtl/irq_event_counter.sv
module irq_event_counter
  import irq_gen_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_ctrl_t    ctrl_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_o <= '0;
    else if (ctrl_i.clr)
      cnt_o <= ctrl_i.load_one ? CNT_ONE : '0;
    else if (ctrl_i.inc && cnt_o != CNT_MAX)
      cnt_o <= cnt_o + CNT_ONE;
  end
endmodule

// File: rtl/irq_ms_prescaler.sv
module irq_ms_prescaler #(
  parameter int TICK_CYCLES = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && !clr_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      pre_q <= '0;
    else if (clr_i)
      pre_q <= '0;
    else if (run_i)
      pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
  end
endmodule

// File: rtl/irq_rise_pulse.sv
module irq_rise_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      level_q <= level_i;
      pulse_o <= level_i && !level_q;
    end
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
  import irq_gen_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int TICK_CYCLES = 125000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] thr_cnt_i,
  input  logic [CNT_W-1:0] thr_ms_i,
  input  logic             tstamp_i,
  input  logic             err_flag_i,
  input  logic             acq_start_i,
  input  logic             acq_stop_i,
  output logic             irq_cnt_o,
  output logic             irq_time_o,
  output logic             irq_err_o
);
  logic             acq_q;
  logic [CNT_W-1:0] ts_cnt;
  logic [CNT_W-1:0] ms_cnt;
  logic             ms_tick;
  logic             hit_cnt, hit_time, ctl_busy, fire;
  cnt_ctrl_t        ts_ctrl, ms_ctrl;

  assign hit_cnt  = acq_q && (thr_cnt_i != '0) && (ts_cnt > thr_cnt_i);
  assign hit_time = acq_q && (thr_ms_i != '0) && (ts_cnt != '0) && (ms_cnt > thr_ms_i);
  assign ctl_busy = acq_start_i || acq_stop_i;
  assign fire     = (hit_cnt || hit_time) && !ctl_busy;

  always_comb begin
    ts_ctrl.clr      = acq_start_i || fire;
    ts_ctrl.load_one = fire && !acq_start_i && tstamp_i;  // carry into next interval
    ts_ctrl.inc      = acq_q && tstamp_i;
    ms_ctrl.clr      = acq_start_i || fire;
    ms_ctrl.load_one = 1'b0;
    ms_ctrl.inc      = ms_tick;
  end

  irq_event_counter #(.W(CNT_W)) u_ts_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ts_ctrl),
    .cnt_o  (ts_cnt)
  );

  irq_event_counter #(.W(CNT_W)) u_ms_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ms_ctrl),
    .cnt_o  (ms_cnt)
  );

  irq_ms_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acq_start_i || fire),
    .run_i  (acq_q),
    .tick_o (ms_tick)
  );

  irq_rise_pulse u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (err_flag_i),
    .pulse_o (irq_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acq_q      <= 1'b0;
      irq_cnt_o  <= 1'b0;
      irq_time_o <= 1'b0;
    end else begin
      // stop wins over a simultaneous start
      if (acq_stop_i)       acq_q <= 1'b0;
      else if (acq_start_i) acq_q <= 1'b1;
      irq_cnt_o  <= hit_cnt && !ctl_busy;
      irq_time_o <= hit_time && !ctl_busy;
    end
  end
endmodule

// File: rtl/irq_pulse_gen_sva.sv
module irq_pulse_gen_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] thr_cnt_i,
  input logic [CNT_W-1:0] thr_ms_i,
  input logic             err_flag_i,
  input logic             acq_stop_i,
  input logic             irq_cnt_o,
  input logic             irq_time_o,
  input logic             irq_err_o
);
  AST_CNT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cnt_o |=> !irq_cnt_o); // R2
  AST_TIME_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_time_o |=> !irq_time_o); // R2
  AST_RESTART_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_cnt_o || irq_time_o) |=> !(irq_cnt_o || irq_time_o)); // R6
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_stop_i |=> !(irq_cnt_o || irq_time_o)); // R8
  AST_ZERO_CNT_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(thr_cnt_i) == '0) |-> !irq_cnt_o); // R9
  AST_ZERO_MS_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(thr_ms_i) == '0) |-> !irq_time_o); // R9
  AST_ERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o |=> !irq_err_o); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o |-> $past(err_flag_i)); // R10
endmodule

bind irq_pulse_gen irq_pulse_gen_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .thr_cnt_i  (thr_cnt_i),
  .thr_ms_i   (thr_ms_i),
  .err_flag_i (err_flag_i),
  .acq_stop_i (acq_stop_i),
  .irq_cnt_o  (irq_cnt_o),
  .irq_time_o (irq_time_o),
  .irq_err_o  (irq_err_o)
);

// File: tb/irq_pulse_gen_bench.sv
`timescale 1ns/1ps
module irq_pulse_gen_bench;
  localparam int CNT_W = 16;
  localparam int TICK  = 8;
  localparam int MAXC  = 200000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W-1:0] thr_cnt = '0, thr_ms = '0;
  logic ts = 0, err = 0, start = 0, stop = 0;
  logic irq_cnt, irq_time, irq_err;

  always #2.5 clk = ~clk;

  irq_pulse_gen #(.CNT_W(CNT_W), .TICK_CYCLES(TICK)) u_irq_pulse_gen (
    .clk_i(clk), .rst_ni(rst_ni), .thr_cnt_i(thr_cnt), .thr_ms_i(thr_ms),
    .tstamp_i(ts), .err_flag_i(err), .acq_start_i(start), .acq_stop_i(stop),
    .irq_cnt_o(irq_cnt), .irq_time_o(irq_time), .irq_err_o(irq_err));

  int n_cmp = 0, n_bad = 0;
  int p_cnt = 0, p_time = 0, p_err = 0;
  string cur_req = "R1";
  bit done = 0;
  logic prev_cnt = 0, prev_time = 0;

  // expected-behaviour model
  logic m_act, m_cnt_o, m_time_o, m_err_o, m_err_q;
  int unsigned m_ts, m_ms, m_pre;
  localparam int unsigned SAT = (1 << CNT_W) - 1;

  function automatic int unsigned sat1(int unsigned v);
    return (v == SAT) ? v : v + 1;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act <= 0; m_cnt_o <= 0; m_time_o <= 0; m_err_o <= 0; m_err_q <= 0;
      m_ts <= 0; m_ms <= 0; m_pre <= 0;
    end else begin
      automatic bit h_c = m_act && thr_cnt != 0 && m_ts > thr_cnt;
      automatic bit h_t = m_act && thr_ms != 0 && m_ts != 0 && m_ms > thr_ms;
      automatic bit busy = start || stop;
      automatic bit f = (h_c || h_t) && !busy;
      m_cnt_o  <= h_c && !busy;
      m_time_o <= h_t && !busy;
      m_err_o  <= err && !m_err_q;
      m_err_q  <= err;
      m_act    <= stop ? 1'b0 : (start ? 1'b1 : m_act);
      if (start) begin
        m_ts <= 0; m_ms <= 0; m_pre <= 0;
      end else if (f) begin
        m_ts <= ts ? 1 : 0; m_ms <= 0; m_pre <= 0;
      end else if (m_act) begin
        if (ts) m_ts <= sat1(m_ts);
        if (m_pre == TICK - 1) begin
          m_pre <= 0; m_ms <= sat1(m_ms);
        end else m_pre <= m_pre + 1;
      end
    end
  end

  task automatic check(string req, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step(bit t, bit e, bit a, bit s);
    ts = t; err = e; start = a; stop = s;
    @(negedge clk);
    check(cur_req, "irq_cnt_o", irq_cnt, m_cnt_o);
    check(cur_req, "irq_time_o", irq_time, m_time_o);
    check("R10", "irq_err_o", irq_err, m_err_o);
    if (prev_cnt && irq_cnt) check("R2", "irq_cnt_o back-to-back", 1, 0);
    if (prev_time && irq_time) check("R2", "irq_time_o back-to-back", 1, 0);
    prev_cnt = irq_cnt; prev_time = irq_time;
    p_cnt += int'(irq_cnt); p_time += int'(irq_time); p_err += int'(irq_err);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, err, 0, 0);
  endtask

  task automatic clr_counts();
    p_cnt = 0; p_time = 0; p_err = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (MAXC) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R1
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", {irq_cnt, irq_time, irq_err}, 0);
    rst_ni = 1;
    @(negedge clk);
    check("R1", "outputs after release", {irq_cnt, irq_time, irq_err}, 0);

    // R3: threshold 3, fourth timestamp triggers
    cur_req = "R3"; thr_cnt = 3; thr_ms = 0;
    step(0, 0, 1, 0); clr_counts();
    for (int i = 0; i < 4; i++) begin step(1, 0, 0, 0); idle(2); end
    idle(5);
    check("R3", "count irq pulses", p_cnt, 1);

    // R7: threshold 1, timestamp every cycle
    cur_req = "R7"; thr_cnt = 1;
    step(0, 0, 1, 0); clr_counts();
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0);
    idle(3);
    check("R7", "count irq pulses, continuous stream", p_cnt, 10);

    // R4 + R6: one timestamp, 2 ms threshold
    cur_req = "R4"; thr_cnt = 0; thr_ms = 2;
    step(0, 0, 1, 0); clr_counts();
    step(1, 0, 0, 0);
    idle(60);
    check("R4", "time irq pulses", p_time, 1);
    check("R6", "no repeat after restart", p_cnt + p_time, 1);

    // R5: no timestamps, time passes
    cur_req = "R5"; thr_ms = 1;
    step(0, 0, 1, 0); clr_counts();
    idle(80);
    check("R5", "time irq without data", p_time, 0);

    // R9: zero thresholds
    cur_req = "R9"; thr_cnt = 0; thr_ms = 0;
    step(0, 0, 1, 0); clr_counts();
    for (int i = 0; i < 50; i++) step(1, 0, 0, 0);
    check("R9", "irqs with zero thresholds", p_cnt + p_time, 0);

    // R8: disarmed, including start+stop together
    cur_req = "R8"; thr_cnt = 1; thr_ms = 1;
    step(0, 0, 1, 1); clr_counts();
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0);
    check("R8", "irqs while disarmed", p_cnt + p_time, 0);

    // R10: held flag gives one pulse; also while disarmed
    cur_req = "R10"; clr_counts();
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);
    step(0, 1, 0, 0); step(0, 0, 0, 0); idle(2);
    check("R10", "error irq pulses", p_err, 2);

    // random mix
    cur_req = "R6";
    for (int i = 0; i < 4000; i++) begin
      if (i % 300 == 0) begin
        thr_cnt = CNT_W'($urandom_range(0, 6));
        thr_ms  = CNT_W'($urandom_range(0, 4));
      end
      step($urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 199) == 0, $urandom_range(0, 399) == 0);
    end
    finish_run();
  end
endmodule